// File: doc/BRIEF.md
# Radio Control Register and Synthesizer Settle Sequencer

This block holds the control state of a 2.4 GHz spread-spectrum transceiver baseband and times the settling of its frequency synthesizer. A small register bus reads a fixed identification byte, and it reads and writes a control byte and a settle-delay byte. Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high.

When receive or transmit is switched on, or a channel change is signalled, the sequencer restarts. In one mode it waits for the synthesizer's lock input and then counts a programmable number of 2 µs ticks. In the other mode it skips the lock input and only counts the ticks. After that it raises a ready output. The block also drives the power-amplifier enable, either automatically from the transmit state or from a register bit, and the half-select for a 64-chip spreading code. A parameter gives the number of clock cycles in one tick. C below stands for that parameter.

Top module: `rfctl_top`

## Requirements
- R1: A read of address 0x00 returns the silicon revision parameter in bits 7:4 and 4'b0111 in bits 3:0, and writes to address 0x00 have no effect on it.
- R2: After reset, the control byte (address 0x03) reads 0x00 and the settle-delay byte (address 0x38) reads 25.
- R3: Control bits 7:2 and all settle-delay bits read back as written, while control bits 1:0 ignore writes and always read as zero.
- R4: With control bit 4 (lock bypass) at 0, ready stays low until the lock input is sampled high, and it rises N*C cycles after the first edge at which the lock input is sampled high, where N is the settle-delay value.
- R5: With lock bypass at 1, the lock input is ignored, and ready rises N*C cycles after the first edge that follows the write enabling receive or transmit.
- R6: A settle-delay of zero raises ready at the edge that ends the lock wait, or at the first edge after enabling when the lock wait is bypassed.
- R7: A rising edge of receive enable (control bit 7) or transmit enable (control bit 6), or a channel-change pulse while either is set, drops ready and reruns the whole settle sequence.
- R8: Ready is low whenever both receive and transmit enable are clear.
- R9: With control bit 3 (PA mode) at 0, the PA enable is high exactly when transmit enable is set and ready is high.
- R10: With PA mode at 1, the PA enable equals control bit 2, whatever the ready and transmit states are.
- R11: The upper-half code select equals control bit 5 when the narrow-code input is 1, and it is 0 otherwise.
- R12: The receive and transmit active outputs equal control bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| synth_locked | input | 1 | Synthesizer lock indication |
| chan_hop | input | 1 | Channel-change pulse, restarts the sequence |
| code_narrow | input | 1 | 1 when 32-chip codes are in use |
| radio_ready | output | 1 | Settle sequence complete |
| pa_on | output | 1 | Power-amplifier enable |
| pn_upper | output | 1 | Selects the upper 32 chips of the code |
| rx_active | output | 1 | Receive enabled |
| tx_active | output | 1 | Transmit enabled |

## Verification
The hardest case to create from the ports is a lock input that arrives only after the sequencer has entered its lock wait. The lock must also be timed so that the count phase and the ready edge can be placed to the exact cycle. To get there, the stimulus keeps the lock input low for a random number of cycles after enabling and checks that ready stays low during that time. It then raises the lock input at a known edge and counts the cycles to ready. Further runs cover a transmit enable that rises while receive is already ready, and a channel change that lands on an active sequence; both must drop ready and rerun the full count.

// File: rtl/rfctl_pkg.sv
package rfctl_pkg;
    localparam logic [7:0] ADDR_ID   = 8'h00;
    localparam logic [7:0] ADDR_CTRL = 8'h03;
    localparam logic [7:0] ADDR_LCNT = 8'h38;

    localparam int B_RX     = 7;
    localparam int B_TX     = 6;
    localparam int B_PNHI   = 5;
    localparam int B_BYPASS = 4;
    localparam int B_PAMODE = 3;
    localparam int B_PAMAN  = 2;

    localparam logic [7:0] CTRL_WMASK = 8'hFC;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOCK  = 2'd1,
        SQ_COUNT = 2'd2,
        SQ_READY = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] lcnt;
    } regs_t;
endpackage

// File: rtl/rfctl_regs.sv
module rfctl_regs
    import rfctl_pkg::*;
#(
    parameter logic [3:0] SILICON_REV = 4'h1,
    parameter logic [7:0] LCNT_RESET  = 8'd25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] ctrl,
    output logic [7:0] lcnt
);
    localparam logic [7:0] ID_VALUE = {SILICON_REV, 4'b0111};

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL: r_d.ctrl = bus_wdata & CTRL_WMASK;
                ADDR_LCNT: r_d.lcnt = bus_wdata;
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= 8'h00;
            r_q.lcnt <= LCNT_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_ID:   bus_rdata = ID_VALUE;
            ADDR_CTRL: bus_rdata = r_q.ctrl;
            ADDR_LCNT: bus_rdata = r_q.lcnt;
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign ctrl = r_q.ctrl;
    assign lcnt = r_q.lcnt;
endmodule

// File: rtl/rfctl_settle.sv
module rfctl_settle
    import rfctl_pkg::*;
#(
    parameter int CYCLES_PER_TICK = 250,
    parameter int CNT_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             bypass,
    input  logic             lock,
    input  logic             hop,
    input  logic [CNT_W-1:0] lcnt,
    output logic             ready
);
    localparam int SUB_W = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYCLES_PER_TICK - 1);

    typedef struct packed {
        sq_state_e        state;
        logic [SUB_W-1:0] sub;
        logic [CNT_W-1:0] ticks;
        logic             rx_prev;
        logic             tx_prev;
    } sq_t;

    sq_t s_d, s_q;
    logic any_en;
    logic restart;
    logic [CNT_W:0] ticks_next;
    sq_state_e after_lock;

    always_comb begin
        any_en     = rx_en | tx_en;
        restart    = hop | (rx_en & ~s_q.rx_prev) | (tx_en & ~s_q.tx_prev)
                   | (s_q.state == SQ_IDLE);
        ticks_next = {1'b0, s_q.ticks} + 1'b1;
        after_lock = (lcnt == '0) ? SQ_READY : SQ_COUNT;

        s_d         = s_q;
        s_d.rx_prev = rx_en;
        s_d.tx_prev = tx_en;

        if (!any_en) begin
            s_d.state = SQ_IDLE;
            s_d.sub   = '0;
            s_d.ticks = '0;
        end else if (restart) begin
            s_d.sub   = '0;
            s_d.ticks = '0;
            s_d.state = bypass ? after_lock : SQ_LOCK;
        end else begin
            case (s_q.state)
                SQ_LOCK: begin
                    if (lock) s_d.state = after_lock;
                end
                SQ_COUNT: begin
                    if (s_q.sub == SUB_LAST) begin
                        s_d.sub   = '0;
                        s_d.ticks = ticks_next[CNT_W-1:0];
                        if (ticks_next >= {1'b0, lcnt}) s_d.state = SQ_READY;
                    end else begin
                        s_d.sub = s_q.sub + 1'b1;
                    end
                end
                default: s_d.state = s_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= SQ_IDLE;
            s_q.sub     <= '0;
            s_q.ticks   <= '0;
            s_q.rx_prev <= 1'b0;
            s_q.tx_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = (s_q.state == SQ_READY) & any_en;
endmodule

// File: rtl/rfctl_drive.sv
module rfctl_drive
    import rfctl_pkg::*;
(
    input  logic [7:0] ctrl,
    input  logic       ready,
    input  logic       code_narrow,
    output logic       pa_on,
    output logic       pn_upper,
    output logic       rx_active,
    output logic       tx_active
);
    always_comb begin
        rx_active = ctrl[B_RX];
        tx_active = ctrl[B_TX];
        pa_on     = ctrl[B_PAMODE] ? ctrl[B_PAMAN] : (ctrl[B_TX] & ready);
        pn_upper  = code_narrow & ctrl[B_PNHI];
    end
endmodule

// File: rtl/rfctl_top.sv
module rfctl_top
    import rfctl_pkg::*;
#(
    parameter int         CYCLES_PER_TICK = 250,
    parameter logic [3:0] SILICON_REV     = 4'h1,
    parameter logic [7:0] LCNT_RESET      = 8'd25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       synth_locked,
    input  logic       chan_hop,
    input  logic       code_narrow,
    output logic       radio_ready,
    output logic       pa_on,
    output logic       pn_upper,
    output logic       rx_active,
    output logic       tx_active
);
    logic [7:0] ctrl_w;
    logic [7:0] lcnt_w;

    rfctl_regs #(
        .SILICON_REV(SILICON_REV),
        .LCNT_RESET (LCNT_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ctrl     (ctrl_w),
        .lcnt     (lcnt_w)
    );

    rfctl_settle #(
        .CYCLES_PER_TICK(CYCLES_PER_TICK),
        .CNT_W          (8)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_en (ctrl_w[B_RX]),
        .tx_en (ctrl_w[B_TX]),
        .bypass(ctrl_w[B_BYPASS]),
        .lock  (synth_locked),
        .hop   (chan_hop),
        .lcnt  (lcnt_w),
        .ready (radio_ready)
    );

    rfctl_drive u_drive (
        .ctrl       (ctrl_w),
        .ready      (radio_ready),
        .code_narrow(code_narrow),
        .pa_on      (pa_on),
        .pn_upper   (pn_upper),
        .rx_active  (rx_active),
        .tx_active  (tx_active)
    );
endmodule

// File: rtl/rfctl_top_chk.sv
module rfctl_top_chk #(
    parameter logic [3:0] SILICON_REV = 4'h1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic [7:0] ctrl,
    input logic [7:0] lcnt,
    input logic       chan_hop,
    input logic       code_narrow,
    input logic       radio_ready,
    input logic       pa_on,
    input logic       pn_upper
);
    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h00) |-> (bus_rdata == {SILICON_REV, 4'b0111})); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h03) |-> (bus_rdata[1:0] == 2'b00)); // R3

    AST_HOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_hop && (ctrl[7] || ctrl[6]) && (lcnt != 8'd0 || !ctrl[4])) |=> !radio_ready); // R7

    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[7] || ctrl[6]) |-> !radio_ready); // R8

    AST_PA_AUTO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[3] && !radio_ready) |-> !pa_on); // R9

    AST_PA_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[3] |-> (pa_on == ctrl[2])); // R10

    AST_PN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !code_narrow |-> !pn_upper); // R11
endmodule

bind rfctl_top rfctl_top_chk #(.SILICON_REV(SILICON_REV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .ctrl       (ctrl_w),
    .lcnt       (lcnt_w),
    .chan_hop   (chan_hop),
    .code_narrow(code_narrow),
    .radio_ready(radio_ready),
    .pa_on      (pa_on),
    .pn_upper   (pn_upper)
);

// File: tb/rfctl_top_test.sv
`timescale 1ns/1ps
module rfctl_top_test;
    localparam int         C   = 4;
    localparam logic [3:0] REV = 4'h2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       synth_locked = 1'b0;
    logic       chan_hop = 1'b0;
    logic       code_narrow = 1'b0;
    logic       radio_ready, pa_on, pn_upper, rx_active, tx_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rfctl_top #(.CYCLES_PER_TICK(C), .SILICON_REV(REV), .LCNT_RESET(8'd25)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .synth_locked(synth_locked),
        .chan_hop(chan_hop), .code_narrow(code_narrow), .radio_ready(radio_ready),
        .pa_on(pa_on), .pn_upper(pn_upper), .rx_active(rx_active), .tx_active(tx_active)
    );

    function automatic int exp_delay(input int n);
        return 1 + n * C;
    endfunction

    function automatic logic exp_pa(input logic [7:0] v, input logic rdy);
        return v[3] ? v[2] : (v[6] & rdy);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input logic [7:0] a, input int exp, input string req);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic count_ready(output int n);
        n = 0;
        while (!radio_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] v;
        int cnt;
        int d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        read_check(8'h00, {REV, 4'b0111}, "R1 id value");
        read_check(8'h03, 0, "R2 ctrl reset");
        read_check(8'h38, 25, "R2 lcnt reset");
        check("R8 ready low after reset", int'(radio_ready), 0);

        // ID is not writable
        bus_write(8'h00, 8'hA5);
        read_check(8'h00, {REV, 4'b0111}, "R1 id after write");

        // readback and reserved bits
        bus_write(8'h03, 8'h2F);
        read_check(8'h03, 8'h2C, "R3 reserved bits zero");
        bus_write(8'h38, 8'h5A);
        read_check(8'h38, 8'h5A, "R3 lcnt readback");
        bus_write(8'h03, 8'h00);

        // zero count, bypassed
        bus_write(8'h38, 8'd0);
        bus_write(8'h03, 8'h90);
        count_ready(n);
        check("R6 zero count bypass", n, 1);

        // zero count, lock used
        bus_write(8'h03, 8'h00);
        bus_write(8'h03, 8'h80);
        repeat (3) @(negedge clk);
        check("R4 ready waits for lock", int'(radio_ready), 0);
        synth_locked = 1'b1;
        count_ready(n);
        check("R6 zero count after lock", n, 1);
        synth_locked = 1'b0;

        // tx rising while rx is ready restarts the sequence
        bus_write(8'h03, 8'h00);
        bus_write(8'h38, 8'd3);
        bus_write(8'h03, 8'h90);
        count_ready(n);
        check("R5 bypass delay", n, exp_delay(3));
        bus_write(8'h03, 8'hD0);
        @(negedge clk);
        check("R7 tx rise drops ready", int'(radio_ready), 0);
        count_ready(n);
        check("R7 rerun after tx rise", n, 3 * C);
        check("R9 auto pa after ready", int'(pa_on), 1);

        // channel change restarts
        @(negedge clk);
        chan_hop = 1'b1;
        @(negedge clk);
        chan_hop = 1'b0;
        check("R7 hop drops ready", int'(radio_ready), 0);
        count_ready(n);
        check("R7 rerun after hop", n, 3 * C);

        // clearing tx drops auto pa immediately
        bus_write(8'h03, 8'h90);
        check("R9 pa off when tx clears", int'(pa_on), 0);
        check("R12 rx mirror", int'(rx_active), 1);
        check("R12 tx mirror", int'(tx_active), 0);

        // random mix
        for (int it = 0; it < 60; it++) begin
            v   = 8'($urandom);
            cnt = $urandom_range(0, 6);
            code_narrow = 1'($urandom);
            synth_locked = 1'b0;
            bus_write(8'h03, 8'h00);
            check("R8 ready low when idle", int'(radio_ready), 0);
            bus_write(8'h38, 8'(cnt));
            bus_write(8'h03, v);
            read_check(8'h03, int'(v & 8'hFC), "R3 ctrl readback");
            check("R11 pn select", int'(pn_upper), int'(code_narrow & v[5]));
            check("R12 rx/tx mirror", int'({rx_active, tx_active}), int'(v[7:6]));
            if (!(v[7] | v[6])) begin
                repeat (4) @(negedge clk);
                check("R8 ready stays low", int'(radio_ready), 0);
                check("R10 pa when idle", int'(pa_on), int'(exp_pa(v, 1'b0)));
            end else if (v[4]) begin
                count_ready(n);
                check("R5 bypass ignores lock", n, exp_delay(cnt));
                check("R9/R10 pa when ready", int'(pa_on), int'(exp_pa(v, 1'b1)));
            end else begin
                d = $urandom_range(1, 5);
                repeat (d) @(negedge clk);
                check("R4 no ready before lock", int'(radio_ready), 0);
                check("R9/R10 pa before ready", int'(pa_on), int'(exp_pa(v, 1'b0)));
                synth_locked = 1'b1;
                count_ready(n);
                check("R4 delay after lock", n, exp_delay(cnt));
                check("R9/R10 pa when ready", int'(pa_on), int'(exp_pa(v, 1'b1)));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule